// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block is the digital sequencer of a successive-approximation analog-to-digital converter. A one-cycle start request begins a conversion. The block drives a WIDTH-bit trial code to an external DAC. It reads back one comparator bit that reports whether the analog input lies above the DAC level. One bit of the code is decided on each clock. When every bit is resolved, the block presents the code on its result port together with a one-cycle done strobe.

The caller pulses the start input while the block is idle. During the conversion a hold request keeps the external sample-and-hold frozen. The result stays readable until the next conversion completes. Start requests that arrive during a conversion are dropped.

Top module: `sar_adc_ctrl`

## Requirements
- R1: While reset is held and after its release with no start, busy_o, hold_o and done_o are 0 and result_o and dac_code_o are all zeros.
- R2: A start_i sampled high while idle makes dac_code_o equal to a code with only its top bit set, and raises busy_o, from the next cycle.
- R3: Bits are decided from the top bit down to bit 0. While bit k is under trial, dac_code_o carries the bits above k as already decided, bit k set to 1, and every bit below k at 0.
- R4: At the end of each bit-time the bit under trial keeps the value of cmp_above_i: 1 (input above the DAC level) keeps it set, 0 clears it. With a comparator that answers 1 whenever the DAC code is at or below a target, the result equals the target. With one that answers 1 only when the code is strictly below the target, the result is the target minus one, or 0 for a target of 0.
- R5: done_o rises exactly WIDTH cycles after the cycle in which a start was accepted.
- R6: done_o is high for exactly one cycle. result_o takes the new code in that same cycle, and busy_o is low in that cycle.
- R7: A start_i that arrives while busy_o is high is ignored. The conversion timing and the result are the same as without it.
- R8: hold_o is high in every cycle that busy_o is high and low in every other cycle.
- R9: result_o changes only in a cycle where done_o is high. It keeps the previous result through idle time and through the next conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Conversion request, acted on only while idle |
| cmp_above_i | input | 1 | Comparator: 1 when the analog input is above the DAC level |
| dac_code_o | output | WIDTH | Trial code to the external DAC |
| hold_o | output | 1 | Hold request to the sample-and-hold |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle completion strobe |
| result_o | output | WIDTH | Last completed conversion code |

## Verification
Several rules are checked on every cycle against any stimulus:
- the top-bit-only load after an accepted start;
- the single-cycle done strobe and busy falling with it;
- the fixed WIDTH-cycle span from an accepted start to done, measured by a counter that ignores starts during a conversion;
- hold tracking busy;
- the result changing only at done.

Only the bench scenarios can show that the code converges to the right value. They sweep every target with both comparator models, compare the trial code against the expected partial code in each bit-time, and inject mid-conversion starts.

// File: rtl/sar_pkg.sv
package sar_pkg;

  typedef enum logic [0:0] {
    SAR_IDLE = 1'b0,
    SAR_CONV = 1'b1
  } sar_state_e;

endpackage

// File: rtl/sar_step_ctrl.sv
module sar_step_ctrl
  import sar_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  output logic             launch_o,
  output logic             finish_o,
  output logic [WIDTH-1:0] bit_sel_o,
  output logic             busy_o
);

  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(WIDTH - 1);

  sar_state_e       state_q;
  logic [IDX_W-1:0] idx_q;
  logic             stepping;

  assign stepping = (state_q == SAR_CONV);
  assign launch_o = (state_q == SAR_IDLE) && start_i;
  assign finish_o = stepping && (idx_q == '0);
  assign busy_o   = stepping;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SAR_IDLE;
      idx_q   <= '0;
    end else begin
      case (state_q)
        SAR_IDLE: begin
          if (start_i) begin
            state_q <= SAR_CONV;
            idx_q   <= TOP_IDX;
          end
        end
        SAR_CONV: begin
          if (idx_q == '0) begin
            state_q <= SAR_IDLE;
          end else begin
            idx_q <= idx_q - 1'b1;
          end
        end
        default: state_q <= SAR_IDLE;
      endcase
    end
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_sel
    assign bit_sel_o[i] = stepping && (idx_q == IDX_W'(i));
  end

endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             launch_i,
  input  logic [WIDTH-1:0] bit_sel_i,
  input  logic             cmp_above_i,
  output logic [WIDTH-1:0] trial_o
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (i == WIDTH - 1) begin : g_top
      always_ff @(posedge clk) begin
        if (rst)               trial_o[i] <= 1'b0;
        else if (launch_i)     trial_o[i] <= 1'b1;
        else if (bit_sel_i[i]) trial_o[i] <= cmp_above_i;
      end
    end else begin : g_low
      always_ff @(posedge clk) begin
        if (rst)                   trial_o[i] <= 1'b0;
        else if (launch_i)         trial_o[i] <= 1'b0;
        else if (bit_sel_i[i])     trial_o[i] <= cmp_above_i;
        else if (bit_sel_i[i + 1]) trial_o[i] <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/sar_result_reg.sv
module sar_result_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             finish_i,
  input  logic [WIDTH-1:0] trial_i,
  input  logic             cmp_above_i,
  output logic [WIDTH-1:0] result_o,
  output logic             done_o
);

  logic [WIDTH-1:0] final_code;

  if (WIDTH > 1) begin : g_wide
    assign final_code = {trial_i[WIDTH-1:1], cmp_above_i};
  end else begin : g_narrow
    assign final_code = cmp_above_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= finish_i;
      if (finish_i) result_o <= final_code;
    end
  end

endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             cmp_above_i,
  output logic [WIDTH-1:0] dac_code_o,
  output logic             hold_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] result_o
);

  logic             launch;
  logic             finish;
  logic [WIDTH-1:0] bit_sel;
  logic             hold_q;

  sar_step_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .launch_o  (launch),
    .finish_o  (finish),
    .bit_sel_o (bit_sel),
    .busy_o    (busy_o)
  );

  sar_trial_reg #(.WIDTH(WIDTH)) u_trial (
    .clk         (clk),
    .rst         (rst),
    .launch_i    (launch),
    .bit_sel_i   (bit_sel),
    .cmp_above_i (cmp_above_i),
    .trial_o     (dac_code_o)
  );

  sar_result_reg #(.WIDTH(WIDTH)) u_result (
    .clk         (clk),
    .rst         (rst),
    .finish_i    (finish),
    .trial_i     (dac_code_o),
    .cmp_above_i (cmp_above_i),
    .result_o    (result_o),
    .done_o      (done_o)
  );

  always_ff @(posedge clk) begin
    if (rst)         hold_q <= 1'b0;
    else if (launch) hold_q <= 1'b1;
    else if (finish) hold_q <= 1'b0;
  end

  assign hold_o = hold_q;

endmodule

// File: rtl/sar_adc_ctrl_chk.sv
module sar_adc_ctrl_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic [WIDTH-1:0] dac_code_o,
  input logic             hold_o,
  input logic             busy_o,
  input logic             done_o,
  input logic [WIDTH-1:0] result_o
);

  localparam int CNT_W = $clog2(WIDTH + 2) + 1;
  localparam logic [WIDTH-1:0] TOP_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

  logic [CNT_W-1:0] span_q;

  always_ff @(posedge clk) begin
    if (rst)                   span_q <= '0;
    else if (!busy_o && start_i) span_q <= '0;
    else if (busy_o)           span_q <= span_q + 1'b1;
  end

  AST_START_LOADS_TOP: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && start_i) |=> (busy_o && dac_code_o == TOP_ONLY)); // R2

  AST_SPAN_EXACT: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (span_q == CNT_W'(WIDTH))); // R5

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R6

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o); // R6

  AST_HOLD_TRACKS_BUSY: assert property (@(posedge clk) disable iff (rst)
    hold_o == busy_o); // R8

  AST_RESULT_STEADY: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(result_o)); // R9

endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start_i    (start_i),
  .dac_code_o (dac_code_o),
  .hold_o     (hold_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .result_o   (result_o)
);

// File: tb/tb_sar_adc_ctrl.sv
module tb_sar_adc_ctrl;

  localparam int W = 8;
  localparam int NCODES = 1 << W;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic         cmp;
  logic [W-1:0] dac, result;
  logic         hold, busy, done;

  int target = 0;
  bit strict = 1'b0;
  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  // Comparator stand-in: input sits half an LSB above target, or half below in strict mode
  assign cmp = strict ? (int'(dac) < target) : (int'(dac) <= target);

  sar_adc_ctrl #(.WIDTH(W)) dut (
    .clk(clk), .rst(rst), .start_i(start), .cmp_above_i(cmp),
    .dac_code_o(dac), .hold_o(hold), .busy_o(busy), .done_o(done),
    .result_o(result)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic convert(input int tgt, input bit strict_mode, input bit inject);
    int prev_res;
    int exp_res;
    int upper;
    strict = strict_mode;
    target = tgt;
    prev_res = int'(result);
    if (strict_mode) exp_res = (tgt > 0) ? tgt - 1 : 0;
    else             exp_res = tgt;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2", int'(busy), 1);
    for (int k = W - 1; k >= 0; k--) begin
      upper = (exp_res >> (k + 1)) << (k + 1);
      chk(int'(dac) == (upper | (1 << k)), "R3", int'(dac), upper | (1 << k));
      chk(hold == 1'b1 && busy == 1'b1 && done == 1'b0, "R8", int'(hold), 1);
      chk(int'(result) == prev_res, "R9", int'(result), prev_res);
      if (inject && k == W / 2) start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
    end
    chk(done == 1'b1, "R5", int'(done), 1);
    chk(int'(result) == exp_res, inject ? "R7" : "R4", int'(result), exp_res);
    chk(busy == 1'b0 && hold == 1'b0, "R6", int'(busy), 0);
    @(posedge clk);
    @(negedge clk);
    chk(done == 1'b0, "R6", int'(done), 0);
    chk(int'(result) == exp_res, "R9", int'(result), exp_res);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(busy == 0 && hold == 0 && done == 0, "R1", int'({busy, hold, done}), 0);
    chk(result == '0 && dac == '0, "R1", int'(result), 0);
    rst = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(busy == 0 && hold == 0 && done == 0 && result == '0, "R1", int'(busy), 0);

    for (int t = 0; t < NCODES; t++) convert(t, 1'b0, 1'b0);
    for (int t = 0; t < NCODES; t++) convert(t, 1'b1, 1'b0);
    for (int t = 0; t < NCODES; t += 17) convert(t, 1'b0, 1'b1);

    // R9: idle cycles leave the result alone
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(int'(result) == 255, "R9", int'(result), 255);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule